// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break

This block turns characters handed over on a parallel load port into an asynchronous serial stream on a single output line. Each character goes out as a low start bit, the data bits least significant first, an optional parity bit, and one, one and a half or two stop bits. Character length (5 to 8 bits), parity use and sense, stop length and the bit-rate divisor are set by configuration inputs. These are latched when each character starts.

All state is clocked by the transmit clock `tx_clk` and updates on its falling edge. One bit lasts 1, 16 or 64 transmit clocks. A one-entry holding buffer lets the next character be queued while the current one shifts, so consecutive characters leave with no idle gap. A transmit-enable input gates the start of new characters. A break input replaces the idle or frame level with a continuous low. After a break is released, the line is held at mark for one bit time before any further start bit.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, and whenever no character is shifting and no break is active, `txd` is 1 (mark); after reset `in_ready` and `tx_empty` are 1.
- R2: A frame is a 0 start bit followed by N data bits, least significant first, with N = 5 + `cfg_len` (0..3); data bits at or above position N are ignored.
- R3: With `cfg_par_en`=1 a parity bit follows the last data bit. With `cfg_par_odd`=0 it makes the count of ones over data and parity even; with `cfg_par_odd`=1 it makes that count odd.
- R4: Every bit lasts P transmit clocks, with P = 1, 16, 64, 64 for `cfg_div` = 0, 1, 2, 3.
- R5: `cfg_stop`=0 gives one stop bit (P clocks), 1 gives 1.5 stop bits (P + P/2 clocks, or 2 clocks when P = 1), and 2 or 3 gives two stop bits (2P clocks).
- R6: `txd` and all other outputs change only on the falling edge of `tx_clk`.
- R7: A write is taken on a falling edge with `in_valid` and `in_ready` both 1. `in_ready` then stays 0 until that character starts. A character queued during a frame starts on the edge that ends the previous final stop bit.
- R8: While `tx_en` is 0 no new character starts, but a character already shifting completes unchanged.
- R9: When `brk` is 1, `txd` goes to 0 at the next bit boundary (the next edge when idle), which abandons any frame in progress, and stays 0 while `brk` remains 1.
- R10: After `brk` returns to 0, `txd` is 1 for exactly P clocks before a queued character's start bit.
- R11: `tx_empty` is 1 exactly when no frame is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock; state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 2 | Bit-rate divisor select (0: 1, 1: 16, else 64) |
| cfg_len | input | 2 | Character length minus five |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop | input | 2 | Stop length (0: one, 1: one and a half, else two) |
| tx_en | input | 1 | Permits new characters to start |
| brk | input | 1 | Forces a continuous low on the line |
| in_data | input | 8 | Character to send, low bits used |
| in_valid | input | 1 | Character present on `in_data` |
| in_ready | output | 1 | Holding buffer can accept a character |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | No frame is shifting |

## Verification
A write lands in the buffer on the falling edge after it is presented, and the start bit appears on the falling edge after that. The bench drives and samples on rising edges, so each line level is read half a clock after the edge that set it. Once the start bit is seen, the level at every later rising edge k is fixed by k/P. A second queued character must show its start at rising edge T exactly, where T is the arithmetic frame length, and this checks the stop length. Break is checked against the boundary where the current bit ends. The mark after a break must last exactly P sampled edges.

// File: rtl/uart_brk_tx_pkg.sv
`timescale 1ns/1ps
package uart_brk_tx_pkg;
  localparam int CHAR_MAX  = 8;
  localparam int CHAR_MIN  = 5;
  localparam int FRAME_MAX = CHAR_MAX + 4;
  localparam int CNT_W     = 12;
  localparam int DIV_MID   = 16;
  localparam int DIV_HI    = 64;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_BREAK, ENG_GUARD} eng_state_t;

  typedef struct packed {
    logic [1:0] div_sel;
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop_sel;
  } frame_cfg_t;

  function automatic int char_bits(input logic [1:0] len_sel);
    return CHAR_MIN + int'(len_sel);
  endfunction

  function automatic int bit_clocks(input logic [1:0] div_sel);
    case (div_sel)
      2'd0:    return 1;
      2'd1:    return DIV_MID;
      default: return DIV_HI;
    endcase
  endfunction

  function automatic int stop_clocks(input frame_cfg_t cfg);
    int p;
    p = bit_clocks(cfg.div_sel);
    case (cfg.stop_sel)
      2'd0:    return p;
      2'd1:    return (p == 1) ? 2 : p + p / 2;
      default: return 2 * p;
    endcase
  endfunction

  function automatic int frame_clocks(input frame_cfg_t cfg);
    return bit_clocks(cfg.div_sel) * (1 + char_bits(cfg.len_sel) + int'(cfg.par_en))
           + stop_clocks(cfg);
  endfunction

  function automatic logic [CHAR_MAX-1:0] mask_char(input logic [CHAR_MAX-1:0] data,
                                                    input logic [1:0] len_sel);
    logic [CHAR_MAX-1:0] m;
    m = data;
    for (int i = 0; i < CHAR_MAX; i++)
      if (i >= char_bits(len_sel)) m[i] = 1'b0;
    return m;
  endfunction

  function automatic logic parity_bit(input logic [CHAR_MAX-1:0] data, input frame_cfg_t cfg);
    return (^mask_char(data, cfg.len_sel)) ^ cfg.par_odd;
  endfunction

  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [CHAR_MAX-1:0] data,
                                                       input frame_cfg_t cfg);
    logic [FRAME_MAX-1:0] f;
    int n;
    n = char_bits(cfg.len_sel);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++)
      if (i < n) f[i+1] = data[i];
    if (cfg.par_en) f[n+1] = parity_bit(data, cfg);
    return f;
  endfunction
endpackage

// File: rtl/tx_hold_buf.sv
`timescale 1ns/1ps
module tx_hold_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wr_data,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] q
);
  logic push;
  assign wr_ready = !full;
  assign push     = wr_valid && !full;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (push) begin
      full <= 1'b1;
      q    <= wr_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_frame_engine.sv
`timescale 1ns/1ps
module tx_frame_engine
  import uart_brk_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  frame_cfg_t          cfg,
  input  logic                tx_en,
  input  logic                brk,
  input  logic                buf_full,
  input  logic [CHAR_MAX-1:0] buf_data,
  output logic                pop,
  output logic                txd,
  output logic                shifting,
  output logic                at_boundary,
  output logic                frame_start,
  output logic                brk_active
);
  eng_state_t           st;
  logic [CNT_W-1:0]     bit_left, rem, p_lat, p_now, total;
  logic [FRAME_MAX-1:0] shreg, new_frame;
  logic                 txd_q, frame_end;

  assign p_now     = CNT_W'(bit_clocks(cfg.div_sel));
  assign total     = CNT_W'(frame_clocks(cfg));
  assign new_frame = build_frame(buf_data, cfg);

  always_comb begin
    frame_end   = (st == ENG_SHIFT) && (rem == '0);
    at_boundary = (st == ENG_SHIFT) && ((bit_left == '0) || (rem == '0));
    frame_start = tx_en && !brk && buf_full &&
                  ((st == ENG_IDLE) || frame_end || ((st == ENG_GUARD) && (bit_left == '0)));
  end

  assign pop        = frame_start;
  assign txd        = txd_q;
  assign shifting   = (st == ENG_SHIFT);
  assign brk_active = (st == ENG_BREAK);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ENG_IDLE;
      txd_q    <= 1'b1;
      shreg    <= '1;
      bit_left <= '0;
      rem      <= '0;
      p_lat    <= CNT_W'(1);
    end else if (frame_start) begin
      st       <= ENG_SHIFT;
      txd_q    <= new_frame[0];
      shreg    <= {1'b1, new_frame[FRAME_MAX-1:1]};
      bit_left <= p_now - CNT_W'(1);
      rem      <= total - CNT_W'(1);
      p_lat    <= p_now;
    end else begin
      case (st)
        ENG_IDLE: begin
          if (brk) begin
            st    <= ENG_BREAK;
            txd_q <= 1'b0;
          end else begin
            txd_q <= 1'b1;
          end
        end
        ENG_SHIFT: begin
          if (brk && at_boundary) begin
            st    <= ENG_BREAK;
            txd_q <= 1'b0;
          end else if (frame_end) begin
            st    <= ENG_IDLE;
            txd_q <= 1'b1;
          end else begin
            rem <= rem - CNT_W'(1);
            if (bit_left == '0) begin
              txd_q    <= shreg[0];
              shreg    <= {1'b1, shreg[FRAME_MAX-1:1]};
              bit_left <= p_lat - CNT_W'(1);
            end else begin
              bit_left <= bit_left - CNT_W'(1);
            end
          end
        end
        ENG_BREAK: begin
          if (!brk) begin
            st       <= ENG_GUARD;
            txd_q    <= 1'b1;
            bit_left <= p_now - CNT_W'(1);
          end
        end
        default: begin
          if (brk) begin
            st    <= ENG_BREAK;
            txd_q <= 1'b0;
          end else if (bit_left == '0) begin
            st <= ENG_IDLE;
          end else begin
            bit_left <= bit_left - CNT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_brk_tx.sv
`timescale 1ns/1ps
module uart_brk_tx
  import uart_brk_tx_pkg::*;
(
  input  logic                tx_clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_div,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic [1:0]          cfg_stop,
  input  logic                tx_en,
  input  logic                brk,
  input  logic [CHAR_MAX-1:0] in_data,
  input  logic                in_valid,
  output logic                in_ready,
  output logic                txd,
  output logic                tx_empty
);
  frame_cfg_t          cfg;
  logic                buf_full, pop, shifting, at_boundary, frame_start, brk_active;
  logic [CHAR_MAX-1:0] buf_q;

  assign cfg = '{div_sel: cfg_div, len_sel: cfg_len, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, stop_sel: cfg_stop};

  tx_hold_buf #(.W(CHAR_MAX)) u_buf (
    .clk(tx_clk), .rst_n(rst_n), .wr_data(in_data), .wr_valid(in_valid),
    .wr_ready(in_ready), .pop(pop), .full(buf_full), .q(buf_q)
  );

  tx_frame_engine u_eng (
    .clk(tx_clk), .rst_n(rst_n), .cfg(cfg), .tx_en(tx_en), .brk(brk),
    .buf_full(buf_full), .buf_data(buf_q), .pop(pop), .txd(txd),
    .shifting(shifting), .at_boundary(at_boundary), .frame_start(frame_start),
    .brk_active(brk_active)
  );

  assign tx_empty = !shifting;
endmodule

// File: rtl/uart_brk_tx_chk.sv
`timescale 1ns/1ps
module uart_brk_tx_chk (
  input logic tx_clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic shifting,
  input logic at_boundary,
  input logic frame_start,
  input logic brk_active
);
  // R1: idle line marks
  p_idle_mark_r1: assert property (@(negedge tx_clk) disable iff (!rst_n)
    (!shifting && !brk_active) |-> txd);

  // R2: a started frame begins low
  p_start_low_r2: assert property (@(negedge tx_clk) disable iff (!rst_n)
    frame_start |=> (!txd && shifting));

  // R4: level holds between bit boundaries
  p_mid_bit_stable_r4: assert property (@(negedge tx_clk) disable iff (!rst_n)
    (shifting && !at_boundary) |=> $stable(txd));

  // R7: a taken write closes the buffer
  p_one_entry_r7: assert property (@(negedge tx_clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: break drives low
  p_break_low_r9: assert property (@(negedge tx_clk) disable iff (!rst_n)
    brk_active |-> !txd);

  // R10: leaving break returns to mark
  p_guard_mark_r10: assert property (@(negedge tx_clk) disable iff (!rst_n)
    $fell(brk_active) |-> txd);
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
  .tx_clk(tx_clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .txd(txd), .shifting(shifting), .at_boundary(at_boundary),
  .frame_start(frame_start), .brk_active(brk_active)
);

// File: tb/test_uart_brk_tx.sv
`timescale 1ns/1ps
module test_uart_brk_tx;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] c_div = 0, c_len = 3, c_stop = 0;
  logic       c_pe = 0, c_po = 0, tx_en = 1, brk = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic       in_ready, txd, tx_empty;
  int total = 0, bad = 0;

  uart_brk_tx i_uart_brk_tx (
    .tx_clk(clk), .rst_n(rst_n), .cfg_div(c_div), .cfg_len(c_len),
    .cfg_par_en(c_pe), .cfg_par_odd(c_po), .cfg_stop(c_stop), .tx_en(tx_en),
    .brk(brk), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .txd(txd), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per();
    return (c_div == 0) ? 1 : (c_div == 1) ? 16 : 64;
  endfunction

  function automatic int stop_len();
    int p = per();
    if (c_stop == 0) return p;
    if (c_stop == 1) return (p == 1) ? 2 : (3 * p) / 2;
    return 2 * p;
  endfunction

  function automatic int flen();
    return per() * (6 + int'(c_len) + int'(c_pe)) + stop_len();
  endfunction

  function automatic logic exp_at(input int k, input logic [7:0] d);
    int idx = k / per();
    int n = 5 + int'(c_len);
    int ones = 0;
    if (idx == 0) return 1'b0;
    if (idx <= n) return d[idx-1];
    if (c_pe && idx == n + 1) begin
      for (int i = 0; i < n; i++) ones += int'(d[i]);
      return ((ones % 2) == 1) ^ c_po;
    end
    return 1'b1;
  endfunction

  task automatic push(input logic [7:0] d);
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    #1 in_data = d; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // mode 0: search for start, 1: start due at next rising edge, 2: start seen now
  task automatic check_frame(input logic [7:0] d, input int mode);
    int waited = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0, p = per(), n = 5 + int'(c_len);
    int t = flen();
    if (mode != 2) begin
      @(posedge clk);
      while (txd !== 1'b0 && waited < 5000) begin waited++; @(posedge clk); end
    end
    if (mode == 1) check(waited == 0, "R5/R7 queued start follows stop", waited, 0);
    check(tx_empty == 1'b0, "R11 busy during frame", int'(tx_empty), 0);
    for (int k = 0; k < t; k++) begin
      if (k > 0) @(posedge clk);
      if (txd !== exp_at(k, d)) begin
        if ((k % p) == 0 || (k % p) == p - 1) e4++;
        if (k / p <= n) e2++;
        else if (c_pe && k / p == n + 1) e3++;
        else e5++;
      end
    end
    check(e2 == 0, "R2 start and data bits", e2, 0);
    check(e3 == 0, "R3 parity bit", e3, 0);
    check(e4 == 0, "R4 bit boundaries", e4, 0);
    check(e5 == 0, "R5 stop bits", e5, 0);
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx = 0, marks, errs;
    logic [7:0] a, b;
    time tfall;
    repeat (3) @(posedge clk);
    check(txd === 1'b1, "R1 reset line mark", int'(txd), 1);
    check(in_ready === 1'b1, "R1 reset ready", int'(in_ready), 1);
    check(tx_empty === 1'b1, "R11 reset empty", int'(tx_empty), 1);
    #1 rst_n = 1'b1;

    // sweep x1 and x16 over every length, parity and stop choice
    for (int dv = 0; dv < 2; dv++)
      for (int ln = 0; ln < 4; ln++)
        for (int pm = 0; pm < 3; pm++)
          for (int sp = 0; sp < 3; sp++) begin
            c_div = 2'(dv); c_len = 2'(ln); c_pe = (pm != 0); c_po = (pm == 2); c_stop = 2'(sp);
            a = 8'(idx * 73 + 29); b = ~a; idx++;
            fork
              begin push(a); push(b); end
              begin check_frame(a, 0); check_frame(b, 1); end
            join
            @(posedge clk);
            check(txd === 1'b1 && tx_empty === 1'b1, "R1/R11 idle after frames",
                  int'(txd) + 2 * int'(tx_empty), 3);
          end

    // x64 spot checks, including half stop
    c_div = 2; c_len = 3; c_pe = 1; c_po = 0;
    for (int sp = 1; sp < 3; sp++) begin
      c_stop = 2'(sp);
      fork
        begin push(8'hC3); push(8'h1E); end
        begin check_frame(8'hC3, 0); check_frame(8'h1E, 1); end
      join
    end

    // R8: no start while disabled
    c_div = 0; c_pe = 0; c_stop = 0;
    @(posedge clk); #1 tx_en = 1'b0;
    push(8'h33);
    check(in_ready == 1'b0, "R7 buffer holds a character", int'(in_ready), 0);
    errs = 0;
    repeat (30) begin @(posedge clk); if (txd !== 1'b1) errs++; end
    check(errs == 0, "R8 no start while disabled", errs, 0);
    #1 tx_en = 1'b1;
    check_frame(8'h33, 0);

    // R8: disabling mid-frame lets it complete
    c_div = 1;
    fork
      push(8'h96);
      check_frame(8'h96, 0);
      begin
        @(posedge clk);
        while (txd !== 1'b0) @(posedge clk);
        repeat (5) @(posedge clk);
        #1 tx_en = 1'b0;
      end
    join
    #1 tx_en = 1'b1;

    // R9/R10: break mid-frame at x16
    c_len = 3;
    push(8'hFF);
    @(posedge clk);
    while (txd !== 1'b0) @(posedge clk);
    repeat (20) @(posedge clk);
    #1 brk = 1'b1;
    errs = 0;
    for (int k = 21; k < 32; k++) begin @(posedge clk); if (txd !== 1'b1) errs++; end
    check(errs == 0, "R9 break waits for bit boundary", errs, 0);
    @(posedge clk);
    check(txd === 1'b0, "R9 break at boundary", int'(txd), 0);
    errs = 0;
    repeat (40) begin @(posedge clk); if (txd !== 1'b0) errs++; end
    check(errs == 0, "R9 break held low", errs, 0);
    push(8'h5A);
    check(txd === 1'b0, "R9 break low with queued char", int'(txd), 0);
    #1 brk = 1'b0;
    marks = 0;
    @(posedge clk);
    while (txd === 1'b1 && marks < 200) begin marks++; @(posedge clk); end
    check(marks == 16, "R10 mark after break", marks, 16);
    check_frame(8'h5A, 2);

    // R6/R9/R10: break from idle at x1
    c_div = 0;
    @(posedge clk);
    fork
      begin @(negedge txd); tfall = $time; end
      begin #1 brk = 1'b1; end
    join
    check((tfall % 20) == 0, "R6 change on falling edge", int'(tfall % 20), 0);
    @(posedge clk);
    check(txd === 1'b0, "R9 idle break", int'(txd), 0);
    #1 brk = 1'b0;
    @(posedge clk);
    check(txd === 1'b1 && tx_empty === 1'b1, "R10 mark after idle break",
          int'(txd) + 2 * int'(tx_empty), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule